// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two 64-bit operands that are treated as packed signed lanes. A run-time select splits the word into eight byte lanes, four halfword lanes, two word lanes or one 64-bit lane. No carry crosses a lane boundary, so every lane computes on its own in the same cycle. Operands and controls are captured on a clock edge when the input strobe is high, and the result and strobe appear on the outputs after that edge.

A mode input selects wrapping (modular) arithmetic or signed saturating arithmetic. With saturation on, a lane whose true signed result does not fit is clamped to the largest positive or the most negative value of that lane width, following the sign of the true result. In both modes an eight-bit flag vector reports which lanes overflowed, so clipping never goes unnoticed.

Top module: `simd_sat_adder`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by one clock; synchronous reset drives `out_vld`, `sum_out` and `ovf_flags` to zero.
- R2: With `lane_sel` = 2'b00 the word is eight independent 8-bit lanes; no carry or borrow passes between bytes.
- R3: With `lane_sel` = 2'b01 the word is four independent 16-bit lanes (bits 15:0, 31:16, 47:32, 63:48).
- R4: With `lane_sel` = 2'b10 the word is two independent 32-bit lanes.
- R5: With `lane_sel` = 2'b11 the word is a single 64-bit lane.
- R6: With `op_sub` = 1 each lane computes `opa - opb` (two's complement); with `op_sub` = 0 it computes `opa + opb`.
- R7: With `sat_en` = 0 each lane result is the modular result of its width, and the lane's overflow flag is still raised.
- R8: With `sat_en` = 1, a lane whose true signed result exceeds the lane maximum yields the maximum (0x7F followed by 0xFF bytes).
- R9: With `sat_en` = 1, a lane whose true signed result is below the lane minimum yields the minimum (0x80 followed by 0x00 bytes).
- R10: `ovf_flags` bit k is set only when byte k is the lowest byte of a lane and that lane had signed overflow; all other bits are zero.
- R11: When `in_vld` is low, the inputs are not captured: `sum_out` and `ovf_flags` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Capture strobe for operands and controls |
| opa | input | 64 | First packed operand |
| opb | input | 64 | Second packed operand |
| lane_sel | input | 2 | Lane width: 00 byte, 01 halfword, 10 word, 11 full 64 bits |
| op_sub | input | 1 | 1 subtract, 0 add |
| sat_en | input | 1 | 1 signed saturating, 0 wrapping |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| sum_out | output | 64 | Packed lane results |
| ovf_flags | output | 8 | Per-lane signed overflow, on each lane's lowest byte |

## Verification
Operand pairs with all-ones bytes adjacent to small values are added in every lane width, so a leaked carry shows up as a wrong neighbouring lane; the same operands under different widths tell the four splits apart. Pairs of large positive and large negative lane values, added and subtracted, separate wrap from clamp and positive from negative clamping, while the flag vector is compared bit by bit to catch flags on the wrong byte. A long pseudo-random stream covers all combinations of width, operation and mode, and idle cycles with changing inputs show the result is held.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

   typedef enum logic [1:0] {
      LANE_B8  = 2'b00,
      LANE_H16 = 2'b01,
      LANE_W32 = 2'b10,
      LANE_D64 = 2'b11
   } lane_sz_e;

   // number of bytes in a lane, clipped to the datapath byte count
   function automatic int lane_bytes(lane_sz_e sz, int nbytes);
      int lb;
      lb = 1 << int'(sz);
      if (lb > nbytes) lb = nbytes;
      return lb;
   endfunction

endpackage

// File: rtl/lane_map.sv
module lane_map
   import simd_sat_pkg::*;
#(
   parameter int NB = 8
) (
   input  lane_sz_e      sz,
   output logic [NB-1:0] first_b,
   output logic [NB-1:0] top_b
);
   always_comb begin
      int lb;
      lb = lane_bytes(sz, NB);
      for (int i = 0; i < NB; i++) begin
         first_b[i] = ((i & (lb - 1)) == 0);
         top_b[i]   = ((i & (lb - 1)) == (lb - 1));
      end
   end
endmodule

// File: rtl/byte_add_chain.sv
module byte_add_chain #(
   parameter int NB = 8,
   localparam int W = NB * 8
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic          sub,
   input  logic [NB-1:0] first_b,
   output logic [W-1:0]  sum,
   output logic [NB-1:0] ovf_b,
   output logic [NB-1:0] neg_b
);
   logic [NB:0] carry;
   assign carry[0] = sub;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [7:0] a_s, b_s, s_s;
      logic       cin;
      logic [8:0] wide;
      assign a_s  = a[8*i +: 8];
      assign b_s  = sub ? ~b[8*i +: 8] : b[8*i +: 8];
      // carry is cut at every lane start and replaced by the subtract bit
      assign cin  = first_b[i] ? sub : carry[i];
      assign wide = {1'b0, a_s} + {1'b0, b_s} + {8'd0, cin};
      assign s_s  = wide[7:0];
      assign carry[i+1] = wide[8];
      assign sum[8*i +: 8] = s_s;
      // valid only when this byte is the top of its lane
      assign ovf_b[i] = (a_s[7] == b_s[7]) && (s_s[7] != a_s[7]);
      assign neg_b[i] = a_s[7];
   end

   logic unused_carry;
   assign unused_carry = carry[NB];
endmodule

// File: rtl/lane_clamp.sv
module lane_clamp
   import simd_sat_pkg::*;
#(
   parameter int NB = 8,
   localparam int W = NB * 8
) (
   input  lane_sz_e      sz,
   input  logic          sat,
   input  logic [W-1:0]  sum,
   input  logic [NB-1:0] ovf_b,
   input  logic [NB-1:0] neg_b,
   input  logic [NB-1:0] first_b,
   output logic [W-1:0]  res,
   output logic [NB-1:0] flags
);
   always_comb begin
      int lb;
      int t;
      lb = lane_bytes(sz, NB);
      for (int i = 0; i < NB; i++) begin
         t = i | (lb - 1);
         flags[i] = first_b[i] & ovf_b[t];
         if (sat && ovf_b[t]) begin
            if (neg_b[t]) res[8*i +: 8] = (i == t) ? 8'h80 : 8'h00;
            else          res[8*i +: 8] = (i == t) ? 8'h7F : 8'hFF;
         end else begin
            res[8*i +: 8] = sum[8*i +: 8];
         end
      end
   end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
   import simd_sat_pkg::*;
#(
   parameter int W  = 64,
   localparam int NB = W / 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   input  logic [W-1:0]  opa,
   input  logic [W-1:0]  opb,
   input  logic [1:0]    lane_sel,
   input  logic          op_sub,
   input  logic          sat_en,
   output logic          out_vld,
   output logic [W-1:0]  sum_out,
   output logic [NB-1:0] ovf_flags
);
   if ((W % 8) != 0 || (NB & (NB - 1)) != 0) begin : g_bad_width
      $error("simd_sat_adder: W must be 8 times a power of two");
   end

   logic [W-1:0] a_q, b_q;
   lane_sz_e     sz_q;
   logic         sub_q, sat_q, vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q   <= '0;
         b_q   <= '0;
         sz_q  <= LANE_B8;
         sub_q <= 1'b0;
         sat_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) begin
            a_q   <= opa;
            b_q   <= opb;
            sz_q  <= lane_sz_e'(lane_sel);
            sub_q <= op_sub;
            sat_q <= sat_en;
         end
      end
   end

   logic [NB-1:0] first_b, top_b, ovf_b, neg_b;
   logic [W-1:0]  raw_sum;

   lane_map #(.NB(NB)) u_map (
      .sz(sz_q), .first_b(first_b), .top_b(top_b)
   );

   byte_add_chain #(.NB(NB)) u_add (
      .a(a_q), .b(b_q), .sub(sub_q), .first_b(first_b),
      .sum(raw_sum), .ovf_b(ovf_b), .neg_b(neg_b)
   );

   lane_clamp #(.NB(NB)) u_clamp (
      .sz(sz_q), .sat(sat_q), .sum(raw_sum), .ovf_b(ovf_b), .neg_b(neg_b),
      .first_b(first_b), .res(sum_out), .flags(ovf_flags)
   );

   assign out_vld = vld_q;

   // R1
   vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);
   // R1
   vld_fall_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);
   // R11
   hold_res_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> ($stable(sum_out) && $stable(ovf_flags)));
   // R10
   flag_place_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_flags & ~first_b) == '0);
   // R10
   flag_count_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(ovf_flags) <= $countones(top_b));
   // R8 R9
   full_clamp_chk: assert property (@(posedge clk) disable iff (rst)
      (sz_q == LANE_D64 && sat_q && ovf_flags[0]) |->
         (sum_out == {1'b0, {(W-1){1'b1}}} || sum_out == {1'b1, {(W-1){1'b0}}}));
endmodule

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [63:0] opa, opb;
   logic [1:0]  lane_sel;
   logic        op_sub, sat_en;
   logic        out_vld;
   logic [63:0] sum_out;
   logic [7:0]  ovf_flags;

   int n_chk  = 0;
   int n_fail = 0;

   logic [63:0] q_res[$];
   logic [7:0]  q_flg[$];
   string       q_tag[$];
   logic [63:0] last_res;
   logic [7:0]  last_flg;

   always #10 clk = ~clk;

   simd_sat_adder dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
      .lane_sel(lane_sel), .op_sub(op_sub), .sat_en(sat_en),
      .out_vld(out_vld), .sum_out(sum_out), .ovf_flags(ovf_flags)
   );

   task automatic model(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sz, input logic sub, input logic sat,
                        output logic [63:0] r, output logic [7:0] f);
      int w, nl, lo;
      logic signed [67:0] xa, xb, t, mx, mn, v;
      logic ov;
      w  = 8 << sz;
      nl = 64 / w;
      r = '0; f = '0;
      for (int l = 0; l < nl; l++) begin
         lo = l * w;
         xa = '0; xb = '0;
         for (int k = 0; k < w; k++) begin
            xa[k] = a[lo+k];
            xb[k] = b[lo+k];
         end
         if (a[lo+w-1]) xa = xa - (68'sd1 <<< w);
         if (b[lo+w-1]) xb = xb - (68'sd1 <<< w);
         mx = (68'sd1 <<< (w-1)) - 68'sd1;
         mn = -(68'sd1 <<< (w-1));
         t  = sub ? xa - xb : xa + xb;
         ov = (t > mx) || (t < mn);
         v  = (ov && sat) ? ((t > mx) ? mx : mn) : t;
         for (int k = 0; k < w; k++) r[lo+k] = v[k];
         f[lo/8] = ov;
      end
   endtask

   task automatic check(input string tag, input logic [63:0] ar, input logic [63:0] er,
                        input logic [7:0] af, input logic [7:0] ef);
      n_chk++;
      if (ar !== er || af !== ef) begin
         n_fail++;
         $display("FAIL %s: got res=%h flg=%b, expected res=%h flg=%b", tag, ar, af, er, ef);
      end
   endtask

   task automatic drive(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sz, input logic sub, input logic sat);
      logic [63:0] er;
      logic [7:0]  ef;
      model(a, b, sz, sub, sat, er, ef);
      @(negedge clk);
      opa = a; opb = b; lane_sel = sz; op_sub = sub; sat_en = sat; in_vld = 1'b1;
      q_res.push_back(er); q_flg.push_back(ef); q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
         opa = ~opa; opb = opb + 64'h0101; op_sub = ~op_sub;
      end
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (!rst && out_vld) begin
         if (q_res.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1: out_vld high with nothing expected (got 1, expected 0)");
         end else begin
            last_res = q_res.pop_front();
            last_flg = q_flg.pop_front();
            check(q_tag.pop_front(), sum_out, last_res, ovf_flags, last_flg);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung (got timeout, expected completion)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] x;
      string t;
      rst = 1'b1; in_vld = 1'b0; opa = '0; opb = '0; lane_sel = 2'b00;
      op_sub = 1'b0; sat_en = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (out_vld !== 1'b0 || sum_out !== '0 || ovf_flags !== '0) begin
         n_fail++;
         $display("FAIL R1: reset got vld=%b res=%h flg=%b, expected 0/0/0", out_vld, sum_out, ovf_flags);
      end
      rst = 1'b0;

      // R2: byte lanes, carries must not leak
      drive("R2 byte carry cut", 64'h00FF_01FF_FFFF_00FF, 64'h0001_0001_0001_0101, 2'b00, 1'b0, 1'b0);
      // R3 R4 R5: same operands under wider lanes
      drive("R3 half lanes", 64'h00FF_01FF_FFFF_00FF, 64'h0001_0001_0001_0101, 2'b01, 1'b0, 1'b0);
      drive("R4 word lanes", 64'h00FF_01FF_FFFF_00FF, 64'h0001_0001_0001_0101, 2'b10, 1'b0, 1'b0);
      drive("R5 full lane",  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 1'b0);
      // R6: subtract borrows stay in lane
      drive("R6 byte sub", 64'h0000_1000_0100_0005, 64'h0001_0001_0001_0003, 2'b00, 1'b1, 1'b0);
      drive("R6 half sub", 64'h0000_1000_0100_0005, 64'h0001_0001_0001_0003, 2'b01, 1'b1, 1'b0);
      // R7: wrap with flag
      drive("R7 wrap byte", 64'h7F7F_8080_7F00_807F, 64'h0101_FFFF_0100_8001, 2'b00, 1'b0, 1'b0);
      drive("R7 wrap full", 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 1'b0, 1'b0);
      // R8: positive clamp
      drive("R8 sat pos byte", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0102_0304_0506_0708, 2'b00, 1'b0, 1'b1);
      drive("R8 sat pos word", 64'h7FFF_FFF0_0000_0001, 64'h0000_0020_0000_0001, 2'b10, 1'b0, 1'b1);
      drive("R8 sat pos full sub", 64'h7FFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FF00, 2'b11, 1'b1, 1'b1);
      // R9: negative clamp
      drive("R9 sat neg half", 64'h8000_8001_0000_9000, 64'hFFFF_8000_0001_9000, 2'b01, 1'b0, 1'b1);
      drive("R9 sat neg full", 64'h8000_0000_0000_0000, 64'h1, 2'b11, 1'b1, 1'b1);
      drive("R9 sat neg byte sub", 64'h8081_9000_0000_0000, 64'h0102_7F00_0000_0000, 2'b00, 1'b1, 1'b1);
      // R10: flags placement in halfword and word lanes
      drive("R10 half flags", 64'h7FFF_0001_8000_7FFF, 64'h0001_0001_FFFF_0001, 2'b01, 1'b0, 1'b0);
      drive("R10 word flags", 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001, 2'b10, 1'b0, 1'b1);

      // R11: idle cycles with changing inputs keep the result
      idle(4);
      n_chk++;
      if (sum_out !== last_res || ovf_flags !== last_flg) begin
         n_fail++;
         $display("FAIL R11: held got res=%h flg=%b, expected res=%h flg=%b", sum_out, ovf_flags, last_res, last_flg);
      end

      // random stream over every width, op and mode
      x = 64'h9E37_79B9_7F4A_7C15;
      for (int i = 0; i < 200; i++) begin
         logic [63:0] ra, rb;
         x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17); ra = x;
         x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17); rb = x;
         case (x[1:0])
            2'b00: t = "R2 random byte";
            2'b01: t = "R3 random half";
            2'b10: t = "R4 random word";
            default: t = "R5 random full";
         endcase
         drive(t, ra, rb, x[1:0], x[5], x[9]);
         if (x[12]) idle(1);
      end
      idle(3);

      // R1: everything driven came back
      n_chk++;
      if (q_res.size() != 0) begin
         n_fail++;
         $display("FAIL R1: %0d results missing (expected 0)", q_res.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule